// File: doc/BRIEF.md
# Wait-on-reservation stall controller

This block sits in the execute stage of a pipeline and carries out the two wait-on-reservation-set instructions. When a matching instruction issues, the block holds the pipeline in a stall for as long as the load-reserved unit reports a live reservation and no interrupt is pending. Every interrupt counts, whether or not it is enabled. The short-timeout form adds a cycle limit to the wait. When the wait ends, the block gives a one-cycle completion strobe and releases the stall in that same cycle.

The no-timeout form may also end in a trap. The privilege level, the virtualization flag and the two timeout-wait control bits decide whether a trap is possible, and these inputs are sampled when the instruction issues. If the wait is still unresolved after a bounded number of cycles, the block raises either an illegal-instruction exception or a virtual-instruction exception. An input for early termination lets the surrounding core end any wait at any moment, and the instruction then completes normally.

Top module: `wrs_stall_ctrl`

## Requirements
- R1: The block acts only on an issued word that has opcode bits [6:0]=0x73, bits [11:7], [14:12] and [19:15] all zero, and bits [31:20] equal to 0x00D (no-timeout form) or 0x01D (short-timeout form). Any other word produces no stall, no completion and no exception.
- R2: If the reservation is invalid, any pending bit is set, or the early-exit input is high in the issue cycle, the instruction completes in that cycle and the stall stays low.
- R3: While waiting, loss of the reservation gives a completion in that cycle, with the stall low.
- R4: While waiting, any set bit of the raw pending-interrupt vector ends the wait with a completion. No enable is considered.
- R5: While waiting, the early-exit input ends the wait with a completion in that cycle.
- R6: If no other condition occurs, the short-timeout form stalls from the issue cycle onward and completes exactly STO_CYCLES cycles after the issue cycle.
- R7: With no trap armed, the no-timeout form stalls until one of the conditions in R3 to R5 occurs. It never completes or traps on its own.
- R8: Privilege encoding is 0 = U, 1 = S, 3 = M. For the no-timeout form issued below M with the machine timeout-wait bit set, an unresolved wait raises an exception with cause 2 exactly TW_CYCLES cycles after the issue cycle.
- R9: For the no-timeout form issued below M with the virtualization flag set, the hypervisor timeout-wait bit set and the machine bit clear, an unresolved wait raises an exception with cause 22 at the same point as in R8.
- R10: No trap occurs in M-mode, when the governing timeout-wait bit is clear, or for the short-timeout form whatever the control bits are.
- R11: Completion and exception are one-cycle pulses that never occur together. The stall is low in the cycle of either pulse. A completion condition in the bound cycle takes priority over the trap. All outputs are low under reset.
- R12: Mode and control bits are sampled at issue; later changes do not alter the outcome, and a new issue while waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Issued instruction word |
| resv_valid_i | input | 1 | Reservation set is live |
| irq_pend_i | input | IRQ_W | Raw pending-interrupt vector, enables not applied |
| early_exit_i | input | 1 | Core asks to end any wait now |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Hart runs in a virtualized mode |
| tw_mach_i | input | 1 | Machine-level timeout-wait bit |
| tw_hyp_i | input | 1 | Hypervisor-level timeout-wait bit |
| stall_o | output | 1 | Hold the pipeline |
| done_o | output | 1 | Instruction completes this cycle |
| exc_o | output | 1 | Instruction raises an exception this cycle |
| exc_cause_o | output | 5 | Exception cause (2 illegal, 22 virtual) |

## Verification
The bench feeds the decoder the two valid words and several near-miss words, each differing in a single field, to show that only exact matches start a wait. Each way out of a wait is triggered in two positions: in the issue cycle, which gives an immediate completion, and in the middle of a wait, which shows whether the exit is sampled every cycle. The bench runs each trap classification (M-mode, machine bit, hypervisor bit only, short form with bits set) to the cycle bound. This separates the illegal cause from the virtual cause from no trap at all. One case puts a reservation loss exactly in the bound cycle to test that completion wins, and another toggles the control bits after issue.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int INSTR_W = 32;
  localparam int CAUSE_W = 5;
  localparam int PRIV_W  = 2;

  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] F12_NTO    = 12'h00D;
  localparam logic [11:0] F12_STO    = 12'h01D;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

  localparam logic [PRIV_W-1:0] PRIV_M = 2'b11;

  typedef enum logic [1:0] {
    TK_NONE = 2'd0,
    TK_ILL  = 2'd1,
    TK_VIRT = 2'd2
  } trap_kind_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wrs_state_t;
endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
  import wrs_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               hit_o,
  output logic               sto_o
);
  logic zero_fields;
  logic opc_ok;
  logic is_nto;
  logic is_sto;

  always_comb begin
    opc_ok      = (instr_i[6:0] == OPC_SYSTEM);
    zero_fields = (instr_i[19:7] == 13'd0);
    is_nto      = (instr_i[31:20] == F12_NTO);
    is_sto      = (instr_i[31:20] == F12_STO);
    hit_o       = opc_ok && zero_fields && (is_nto || is_sto);
    sto_o       = is_sto;
  end
endmodule

// File: rtl/wrs_trap_sel.sv
module wrs_trap_sel
  import wrs_pkg::*;
(
  input  logic              sto_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic              tw_mach_i,
  input  logic              tw_hyp_i,
  output trap_kind_t        kind_o
);
  logic below_m;

  always_comb begin
    below_m = (priv_i != PRIV_M);
    kind_o  = TK_NONE;
    if (!sto_i && below_m) begin
      if (tw_mach_i) begin
        kind_o = TK_ILL;
      end else if (virt_i && tw_hyp_i) begin
        kind_o = TK_VIRT;
      end
    end
  end
endmodule

// File: rtl/wrs_cycle_timer.sv
module wrs_cycle_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    expired_o = (cnt_q == LAST);
    cnt_en    = clr_i || (en_i && !expired_o);
    cnt_d     = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6
endmodule

// File: rtl/wrs_stall_ctrl.sv
module wrs_stall_ctrl
  import wrs_pkg::*;
#(
  parameter int IRQ_W      = 16,
  parameter int STO_CYCLES = 64,
  parameter int TW_CYCLES  = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_valid_i,
  input  logic [31:0]          instr_i,
  input  logic                 resv_valid_i,
  input  logic [IRQ_W-1:0]     irq_pend_i,
  input  logic                 early_exit_i,
  input  logic [1:0]           priv_i,
  input  logic                 virt_i,
  input  logic                 tw_mach_i,
  input  logic                 tw_hyp_i,
  output logic                 stall_o,
  output logic                 done_o,
  output logic                 exc_o,
  output logic [4:0]           exc_cause_o
);
  wrs_state_t state_q, state_d;
  logic       sto_q, sto_d;
  trap_kind_t kind_q, kind_d;

  logic       dec_hit, dec_sto;
  trap_kind_t issue_kind;
  logic       issue_hit;
  logic       stop_now;
  logic       sto_exp, tw_exp;
  logic       end_wait, trap_now;
  logic       capture;
  logic       waiting;

  wrs_decode u_decode (
    .instr_i (instr_i),
    .hit_o   (dec_hit),
    .sto_o   (dec_sto)
  );

  wrs_trap_sel u_trap_sel (
    .sto_i     (dec_sto),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .tw_mach_i (tw_mach_i),
    .tw_hyp_i  (tw_hyp_i),
    .kind_o    (issue_kind)
  );

  // Short-timeout counter runs only for the bounded form.
  wrs_cycle_timer #(.LIMIT(STO_CYCLES)) u_sto_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (capture),
    .en_i      (waiting && sto_q),
    .expired_o (sto_exp)
  );

  // Bound counter runs only when a trap is armed.
  wrs_cycle_timer #(.LIMIT(TW_CYCLES)) u_tw_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (capture),
    .en_i      (waiting && (kind_q != TK_NONE)),
    .expired_o (tw_exp)
  );

  always_comb begin
    waiting   = (state_q == ST_WAIT);
    issue_hit = issue_valid_i && dec_hit && !waiting;
    stop_now  = !resv_valid_i || (|irq_pend_i) || early_exit_i;
    end_wait  = stop_now || (sto_q && sto_exp);
    trap_now  = !end_wait && (kind_q != TK_NONE) && tw_exp;

    state_d     = state_q;
    sto_d       = sto_q;
    kind_d      = kind_q;
    capture     = 1'b0;
    stall_o     = 1'b0;
    done_o      = 1'b0;
    exc_o       = 1'b0;
    exc_cause_o = '0;

    if (!waiting) begin
      if (issue_hit) begin
        if (stop_now) begin
          done_o = 1'b1;
        end else begin
          stall_o = 1'b1;
          capture = 1'b1;
          state_d = ST_WAIT;
          sto_d   = dec_sto;
          kind_d  = issue_kind;
        end
      end
    end else begin
      if (end_wait) begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end else if (trap_now) begin
        exc_o       = 1'b1;
        exc_cause_o = (kind_q == TK_VIRT) ? CAUSE_VIRT : CAUSE_ILLEGAL;
        state_d     = ST_IDLE;
      end else begin
        stall_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sto_q   <= 1'b0;
      kind_q  <= TK_NONE;
    end else begin
      state_q <= state_d;
      if (capture) begin
        sto_q  <= sto_d;
        kind_q <= kind_d;
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && exc_o)); // R11
  AST_STALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || exc_o) |-> !stall_o); // R11
  AST_RESV_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !resv_valid_i) |-> done_o); // R3
  AST_IRQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && (|irq_pend_i)) |-> done_o); // R4
  AST_EXIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && early_exit_i) |-> done_o); // R5
  AST_STO_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> !sto_q); // R10
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (exc_cause_o == CAUSE_ILLEGAL || exc_cause_o == CAUSE_VIRT)); // R8
  AST_RESULT_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || exc_o) |=> (state_q == ST_IDLE)); // R11
endmodule

// File: tb/test_wrs_stall_ctrl.sv
module test_wrs_stall_ctrl;
  localparam int IRQ_W = 8;
  localparam int STO   = 16;
  localparam int TW    = 40;
  localparam int WD    = 20000;

  localparam logic [31:0] W_NTO = 32'h00D0_0073;
  localparam logic [31:0] W_STO = 32'h01D0_0073;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue_valid = 1'b0;
  logic [31:0]      instr = 32'h0;
  logic             resv = 1'b1;
  logic [IRQ_W-1:0] irq = '0;
  logic             quit = 1'b0;
  logic [1:0]       priv = 2'b00;
  logic             virt = 1'b0;
  logic             twm = 1'b0;
  logic             twh = 1'b0;
  logic             stall, done, exc;
  logic [4:0]       cause;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R11";

  // reference model state
  int m_wait = 0;
  int m_el = 0;
  int m_sto = 0;
  int m_kind = 0;

  always #5 clk = ~clk;

  wrs_stall_ctrl #(.IRQ_W(IRQ_W), .STO_CYCLES(STO), .TW_CYCLES(TW)) i_wrs_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid), .instr_i(instr),
    .resv_valid_i(resv), .irq_pend_i(irq), .early_exit_i(quit), .priv_i(priv),
    .virt_i(virt), .tw_mach_i(twm), .tw_hyp_i(twh), .stall_o(stall),
    .done_o(done), .exc_o(exc), .exc_cause_o(cause)
  );

  always @(negedge clk) begin
    int e_st, e_dn, e_ex, e_ca, stop, trap;
    e_st = 0; e_dn = 0; e_ex = 0; e_ca = 0;
    if (!rst_n) begin
      m_wait = 0;
    end else begin
      stop = (!resv || irq != 0 || quit) ? 1 : 0;
      if (m_wait == 0) begin
        if (issue_valid && (instr == W_NTO || instr == W_STO)) begin
          if (stop != 0) begin
            e_dn = 1;
          end else begin
            e_st = 1; m_wait = 1; m_el = 0;
            m_sto = (instr == W_STO) ? 1 : 0;
            m_kind = 0;
            if (m_sto == 0 && priv != 2'b11) begin
              if (twm) m_kind = 2;
              else if (virt && twh) m_kind = 22;
            end
          end
        end
      end else begin
        m_el++;
        if (m_sto != 0 && m_el >= STO) stop = 1;
        trap = (stop == 0 && m_kind != 0 && m_el >= TW) ? 1 : 0;
        if (stop != 0) begin
          e_dn = 1; m_wait = 0;
        end else if (trap != 0) begin
          e_ex = 1; e_ca = m_kind; m_wait = 0;
        end else begin
          e_st = 1;
        end
      end
    end
    n_chk++;
    if (stall !== e_st[0] || done !== e_dn[0] || exc !== e_ex[0] ||
        (e_ex != 0 && int'(cause) != e_ca)) begin
      n_bad++;
      $display("FAIL %s t=%0t stall/done/exc/cause got %b/%b/%b/%0d expected %0d/%0d/%0d/%0d",
               cur_req, $time, stall, done, exc, cause, e_st, e_dn, e_ex, e_ca);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic issue(input logic [31:0] w);
    @(posedge clk); #1;
    issue_valid = 1'b1; instr = w;
    @(posedge clk); #1;
    issue_valid = 1'b0; instr = 32'h0000_0013;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      summary();
    end
  end

  initial begin
    cur_req = "R11";
    tick(4);
    rst_n = 1'b1;
    tick(2);

    cur_req = "R1";
    issue(32'h00D0_00F3); tick(2);
    issue(32'h00D0_1073); tick(2);
    issue(32'h00D0_8073); tick(2);
    issue(32'h00C0_0073); tick(2);
    issue(32'h00D0_0072); tick(2);
    issue(32'h02D0_0073); tick(2);

    cur_req = "R2";
    resv = 1'b0; issue(W_NTO); tick(1); resv = 1'b1;
    irq = 8'h01; issue(W_STO); tick(1); irq = '0;
    quit = 1'b1; issue(W_NTO); tick(1); quit = 1'b0;
    tick(2);

    cur_req = "R3";
    issue(W_NTO); tick(5); resv = 1'b0; tick(1); resv = 1'b1; tick(2);

    cur_req = "R4";
    issue(W_NTO); tick(3); irq = 8'h80; tick(1); irq = '0; tick(2);

    cur_req = "R5";
    issue(W_STO); tick(4); quit = 1'b1; tick(1); quit = 1'b0; tick(2);

    cur_req = "R6";
    issue(W_STO); tick(STO + 3);

    cur_req = "R7";
    priv = 2'b00; issue(W_NTO); tick(TW + 10);
    resv = 1'b0; tick(1); resv = 1'b1; tick(2);

    cur_req = "R8";
    twm = 1'b1; priv = 2'b00; issue(W_NTO); tick(TW + 3);
    priv = 2'b01; issue(W_NTO); tick(TW + 3);

    cur_req = "R9";
    twm = 1'b0; twh = 1'b1; virt = 1'b1; priv = 2'b00;
    issue(W_NTO); tick(TW + 3);
    priv = 2'b01; twm = 1'b1; issue(W_NTO); tick(TW + 3);
    twm = 1'b0; twh = 1'b0; virt = 1'b0; priv = 2'b00;

    cur_req = "R10";
    priv = 2'b11; twm = 1'b1; issue(W_NTO); tick(TW + 5);
    resv = 1'b0; tick(1); resv = 1'b1;
    priv = 2'b00; issue(W_STO); tick(STO + 3);
    twm = 1'b0; virt = 1'b0; twh = 1'b1; issue(W_NTO); tick(TW + 5);
    resv = 1'b0; tick(1); resv = 1'b1; twh = 1'b0; tick(2);

    cur_req = "R11";
    twm = 1'b1; priv = 2'b00; issue(W_NTO); tick(TW - 1);
    resv = 1'b0; tick(1); resv = 1'b1; tick(3);
    twm = 1'b0;

    cur_req = "R12";
    issue(W_NTO); twm = 1'b1; tick(3);
    issue_valid = 1'b1; instr = W_STO; tick(1); issue_valid = 1'b0;
    tick(TW + 5); resv = 1'b0; tick(1); resv = 1'b1; twm = 1'b0;
    tick(3);

    summary();
  end
endmodule